// File: doc/BRIEF.md
# Drive-to-Buffer DMA Write Engine

This block moves bytes between a disc-drive decoder port and a byte-wide buffer memory. A five-bit control word chooses between reading the buffer out to the decoder and writing decoder bytes into the buffer. In the write direction, the engine can also store one error-pointer byte for every eight stream bytes. That pointer byte goes either to a separate region named by its own address counter, or in line straight after the eight bytes. The engine can also put a twelve-byte dummy sync header ahead of the sector data.

The engine holds two address counters: a stream counter and a pointer counter. Either can be preset through a load port. Each memory access is a request that completes only in a cycle where the grant input is high. A low grant stalls the engine with nothing lost. Writing the control word restarts the sequencing. A synchronous soft reset returns everything to zero.

The states and their transitions are:
- IDLE: the engine waits. It goes to READ, SYNC or DATA in the cycle after a control write, chosen by the mode.
- SYNC: the engine writes the header. It goes to PTR when a pointer group fills, and to DATA after the twelfth header byte.
- DATA: the engine writes decoder bytes. It goes to PTR when a pointer group fills.
- PTR: the engine writes the pointer byte. It then returns to SYNC if header bytes remain, and otherwise to DATA.
- READ: the engine streams the buffer to the decoder.

Any control write forces IDLE.

Top module: `drv_dma_engine`

## Requirements
- R1: While control bit 0 is 0, the engine makes no memory request and no decoder handshake, whatever the other control bits hold.
- R2: With control bit 0 at 1, control bit 1 picks the direction. At 0, the engine reads the buffer at the stream address and hands each byte to the decoder in the granted cycle. At 1, it writes accepted decoder bytes at the stream address.
- R3: Control bit 2 enables pointer bytes, and only in the write direction. Without it, no pointer byte is ever written, even if bit 3 is set.
- R4: Separated mode (bit 3 = 0) writes one pointer byte at the pointer address after every 8 stream bytes. Bit i of that byte is the error flag of the i-th byte of the group.
- R5: Mixed mode (bit 3 = 1) writes the pointer byte at the stream address, directly after the 8th byte of the group. The pointer counter keeps its value throughout.
- R6: Control bit 4 in the write direction puts 12 header bytes at the stream address before any decoder byte. The header is 00h, then ten FFh, then 00h. Header bytes count toward pointer groups with error flag 0. Bit 4 has no effect in the read direction.
- R7: Each counter steps by 1 per byte placed in its own region, and wraps from all-ones to zero.
- R8: A memory access takes place only in a cycle with both request and grant high. While grant is low, the address and data stay put and no byte is lost.
- R9: A control write restarts the pointer grouping and the header. The address counters keep their values, and the load inputs preset them.
- R10: Reset or soft reset clears both counters and the mode, and leaves the engine in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: run, direction, pointer enable, pointer layout, header enable |
| cnt_ld_drv | input | 1 | Preset the stream address counter |
| cnt_ld_ptr | input | 1 | Preset the pointer address counter |
| cnt_ld_val | input | ADDR_W | Preset value |
| dec_valid | input | 1 | Decoder offers a byte |
| dec_data | input | 8 | Decoder byte |
| dec_err | input | 1 | Error flag of the offered byte |
| dec_ready | output | 1 | Decoder byte accepted this cycle |
| dec_oready | input | 1 | Decoder can take a buffer byte |
| dec_ovalid | output | 1 | Buffer byte to the decoder is valid |
| dec_odata | output | 8 | Buffer byte to the decoder |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_gnt | input | 1 | Grant; the access completes this cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the granted cycle |

## Verification
The assertions assume a well-behaved decoder and control port. The decoder holds its byte and error flag steady until the byte is accepted. Control writes and counter presets arrive only while no access is pending, with the decoder request lines low. The stimulus keeps to this by issuing control writes and presets with grant held low and all decoder inputs deasserted. It also changes decoder inputs only at the falling edge, after the previous byte has been taken. Grant is held low on a repeating pattern, so the stall checks see header and pointer writes held back.

// File: rtl/drv_dma_pkg.sv
package drv_dma_pkg;
    localparam int unsigned CTL_W    = 5;
    localparam int unsigned CB_RUN   = 0;
    localparam int unsigned CB_DIR   = 1;
    localparam int unsigned CB_PTR   = 2;
    localparam int unsigned CB_MIX   = 3;
    localparam int unsigned CB_SYNC  = 4;
    localparam int unsigned SYNC_LEN = 12;
    localparam int unsigned SYNC_IW  = $clog2(SYNC_LEN + 1);
    localparam int unsigned GRP_LEN  = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DATA,
        ST_PTR,
        ST_READ
    } dma_state_e;

    typedef struct packed {
        logic run;
        logic to_buf;
        logic ptr_en;
        logic mixed;
        logic sync_en;
    } dma_mode_t;

    function automatic logic [7:0] sync_byte(input logic [SYNC_IW-1:0] idx);
        return (idx == '0 || idx == SYNC_IW'(SYNC_LEN - 1)) ? 8'h00 : 8'hFF;
    endfunction
endpackage

// File: rtl/dma_ctl_reg.sv
module dma_ctl_reg
    import drv_dma_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output dma_mode_t        mode,
    output logic             start
);
    dma_mode_t dec;

    always_comb begin
        dec.run     = ctl_wdata[CB_RUN];
        dec.to_buf  = dec.run & ctl_wdata[CB_DIR];
        dec.ptr_en  = dec.to_buf & ctl_wdata[CB_PTR];
        dec.mixed   = dec.ptr_en & ctl_wdata[CB_MIX];
        dec.sync_en = dec.to_buf & ctl_wdata[CB_SYNC];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            mode  <= '0;
            start <= 1'b0;
        end else begin
            start <= ctl_we;
            if (ctl_we) mode <= dec;
        end
    end

    // R3 / R6: dependent mode bits never stand without their enables
    p_mode_gating_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.ptr_en || mode.sync_en) |-> (mode.run && mode.to_buf));
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) q <= '0;
        else if (ld)            q <= ld_val;
        else if (inc)           q <= q + W'(1);
    end

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (inc && !ld) |=> (q == W'($past(q) + W'(1))));
    p_addr_load_r9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        ld |=> (q == $past(ld_val)));
endmodule

// File: rtl/dma_ptr_pack.sv
module dma_ptr_pack #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic         clr,
    input  logic         push,
    input  logic         flag,
    output logic         last,
    output logic [N-1:0] flags
);
    localparam int unsigned IW = $clog2(N);
    logic [IW-1:0] idx_q;

    assign last = (idx_q == IW'(N - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || clr) begin
            idx_q <= '0;
            flags <= '0;
        end else if (push) begin
            flags[idx_q] <= flag;
            idx_q        <= last ? '0 : idx_q + IW'(1);
        end
    end

    p_group_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flags == '0 && !last));
endmodule

// File: rtl/drv_dma_engine.sv
module drv_dma_engine
    import drv_dma_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              cnt_ld_drv,
    input  logic              cnt_ld_ptr,
    input  logic [ADDR_W-1:0] cnt_ld_val,
    input  logic              dec_valid,
    input  logic [7:0]        dec_data,
    input  logic              dec_err,
    output logic              dec_ready,
    input  logic              dec_oready,
    output logic              dec_ovalid,
    output logic [7:0]        dec_odata,
    output logic              mem_req,
    output logic              mem_we,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    dma_state_e         state_q, state_d;
    dma_mode_t          mode;
    logic               start;
    logic [SYNC_IW-1:0] sync_idx_q;
    logic [ADDR_W-1:0]  drv_addr, ptr_addr;
    logic [GRP_LEN-1:0] ptr_flags;
    logic               grp_last, fire, sync_left;
    logic               drv_inc, ptr_inc, grp_push, grp_flag, grp_clr;

    dma_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .mode(mode), .start(start)
    );

    dma_addr_cnt #(.W(ADDR_W)) u_drv_cnt (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ld(cnt_ld_drv), .ld_val(cnt_ld_val), .inc(drv_inc), .q(drv_addr)
    );

    dma_addr_cnt #(.W(ADDR_W)) u_ptr_cnt (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ld(cnt_ld_ptr), .ld_val(cnt_ld_val), .inc(ptr_inc), .q(ptr_addr)
    );

    dma_ptr_pack #(.N(GRP_LEN)) u_pack (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .clr(grp_clr), .push(grp_push), .flag(grp_flag),
        .last(grp_last), .flags(ptr_flags)
    );

    assign fire      = mem_req && mem_gnt;
    assign sync_left = mode.sync_en && (sync_idx_q != SYNC_IW'(SYNC_LEN));
    assign drv_inc   = fire && (state_q != ST_PTR || mode.mixed);
    assign ptr_inc   = fire && (state_q == ST_PTR) && !mode.mixed;
    assign grp_push  = fire && (state_q == ST_SYNC || state_q == ST_DATA);
    assign grp_flag  = (state_q == ST_DATA) && dec_err;
    assign grp_clr   = start || (fire && state_q == ST_PTR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state_q    <= ST_IDLE;
            sync_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (start)                            sync_idx_q <= '0;
            else if (fire && state_q == ST_SYNC)  sync_idx_q <= sync_idx_q + SYNC_IW'(1);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && mode.run) begin
                    if (!mode.to_buf)     state_d = ST_READ;
                    else if (mode.sync_en) state_d = ST_SYNC;
                    else                   state_d = ST_DATA;
                end
            end
            ST_SYNC: begin
                if (fire) begin
                    if (mode.ptr_en && grp_last)                    state_d = ST_PTR;
                    else if (sync_idx_q == SYNC_IW'(SYNC_LEN - 1)) state_d = ST_DATA;
                end
            end
            ST_DATA: if (fire && mode.ptr_en && grp_last) state_d = ST_PTR;
            ST_PTR:  if (fire) state_d = sync_left ? ST_SYNC : ST_DATA;
            ST_READ: state_d = ST_READ;
            default: state_d = ST_IDLE;
        endcase
        if (ctl_we) state_d = ST_IDLE;
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = drv_addr;
        mem_wdata  = '0;
        dec_ready  = 1'b0;
        dec_ovalid = 1'b0;
        dec_odata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SYNC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = sync_byte(sync_idx_q);
            end
            ST_DATA: begin
                mem_req   = dec_valid;
                mem_we    = 1'b1;
                mem_wdata = dec_data;
                dec_ready = mem_gnt;
            end
            ST_PTR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = mode.mixed ? drv_addr : ptr_addr;
                mem_wdata = ptr_flags;
            end
            ST_READ: begin
                mem_req    = dec_oready;
                dec_ovalid = dec_oready && mem_gnt;
                dec_odata  = mem_rdata;
            end
            default: ;
        endcase
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!mem_req && !dec_ready && !dec_ovalid));
    p_read_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |-> (!mem_we && !dec_ready && !mode.to_buf));
    p_ptr_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PTR) |-> mode.ptr_en);
    p_mixed_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (mode.mixed && !cnt_ld_ptr) |=> $stable(ptr_addr));
    p_sync_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_idx_q <= SYNC_IW'(SYNC_LEN));
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (mem_req && !mem_gnt && !ctl_we && !cnt_ld_drv && !cnt_ld_ptr &&
         (state_q == ST_SYNC || state_q == ST_PTR))
        |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
    p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (state_q == ST_IDLE && drv_addr == '0 && ptr_addr == '0));
endmodule

// File: tb/tb_drv_dma_engine.sv
module tb_drv_dma_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int WATCHDOG   = 150000;
    localparam int AMOD       = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, soft_rst, ctl_we, cnt_ld_drv, cnt_ld_ptr;
    logic [4:0]    ctl_wdata;
    logic [AW-1:0] cnt_ld_val, mem_addr;
    logic          dec_valid, dec_err, dec_ready, dec_oready, dec_ovalid;
    logic [7:0]    dec_data, dec_odata, mem_wdata, mem_rdata;
    logic          mem_req, mem_we, mem_gnt;

    drv_dma_engine #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .cnt_ld_drv(cnt_ld_drv), .cnt_ld_ptr(cnt_ld_ptr), .cnt_ld_val(cnt_ld_val),
        .dec_valid(dec_valid), .dec_data(dec_data), .dec_err(dec_err), .dec_ready(dec_ready),
        .dec_oready(dec_oready), .dec_ovalid(dec_ovalid), .dec_odata(dec_odata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // bench-side buffer memory content
    assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5;

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    string cur = "";
    logic [AW+7:0] exp_q[$];
    int m_da = 0, m_pa = 0, m_grp = 0;
    logic [7:0] m_flags = '0;
    bit m_ptr, m_mix, m_sync;
    bit pv, pe, po, stall, quiet, acc;
    logic [7:0] pd;
    int cyc = 0, rd_cnt = 0;

    function automatic void chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endfunction

    function automatic void model_item(logic [7:0] d, bit e);
        exp_q.push_back({AW'(m_da), d});
        m_da = (m_da + 1) % AMOD;
        if (m_ptr) begin
            m_flags[m_grp] = e;
            m_grp++;
            if (m_grp == 8) begin
                if (m_mix) begin
                    exp_q.push_back({AW'(m_da), m_flags});
                    m_da = (m_da + 1) % AMOD;
                end else begin
                    exp_q.push_back({AW'(m_pa), m_flags});
                    m_pa = (m_pa + 1) % AMOD;
                end
                m_grp = 0;
                m_flags = '0;
            end
        end
    endfunction

    function automatic void model_start(logic [4:0] c);
        bit run, tb;
        run    = c[0];
        tb     = run & c[1];
        m_ptr  = tb & c[2];
        m_mix  = m_ptr & c[3];
        m_sync = tb & c[4];
        m_grp  = 0;
        m_flags = '0;
        if (m_sync)
            for (int i = 0; i < 12; i++)
                model_item((i == 0 || i == 11) ? 8'h00 : 8'hFF, 1'b0);
    endfunction

    task automatic step();
        logic [AW+7:0] e;
        @(negedge clk);
        cyc++;
        dec_valid  = pv;
        dec_data   = pd;
        dec_err    = pe;
        dec_oready = po;
        mem_gnt    = stall ? ((cyc % 3) != 1) : 1'b1;
        #1;
        acc = dec_valid && dec_ready;
        if (quiet)
            chk(!mem_req && !dec_ready && !dec_ovalid, cur,
                int'({mem_req, dec_ready, dec_ovalid}), 0);
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, {cur, " unexpected write"}, int'({mem_addr, mem_wdata}), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk({mem_addr, mem_wdata} == e, cur, int'({mem_addr, mem_wdata}), int'(e));
                end
            end else begin
                chk(mem_addr == AW'(m_da) && dec_ovalid &&
                    dec_odata == (8'(m_da) ^ 8'(m_da >> 8) ^ 8'hA5),
                    cur, int'({mem_addr, dec_odata}), m_da);
                m_da = (m_da + 1) % AMOD;
                rd_cnt++;
            end
        end
        @(posedge clk);
    endtask

    task automatic send(int n, int seed);
        for (int i = 0; i < n; i++) begin
            pd = 8'(seed * 37 + i * 11);
            pe = ((i * 5 + seed) % 3) == 0;
            pv = 1'b1;
            model_item(pd, pe);
            do step(); while (!acc);
        end
        pv = 1'b0;
    endtask

    task automatic drain();
        int k = 0;
        while (exp_q.size() != 0 && k < 400) begin
            step();
            k++;
        end
        chk(exp_q.size() == 0, {cur, " pending writes"}, exp_q.size(), 0);
        exp_q.delete();
        repeat (3) step();
    endtask

    task automatic ctl_write(logic [4:0] v);
        pv = 1'b0; po = 1'b0;
        @(negedge clk);
        dec_valid = 1'b0; dec_oready = 1'b0; mem_gnt = 1'b0;
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        model_start(v);
    endtask

    task automatic load(bit to_ptr, int v);
        @(negedge clk);
        mem_gnt = 1'b0;
        cnt_ld_val = AW'(v);
        if (to_ptr) begin cnt_ld_ptr = 1'b1; m_pa = v; end
        else        begin cnt_ld_drv = 1'b1; m_da = v; end
        @(negedge clk);
        cnt_ld_drv = 1'b0; cnt_ld_ptr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; soft_rst = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        cnt_ld_drv = 1'b0; cnt_ld_ptr = 1'b0; cnt_ld_val = '0;
        dec_valid = 1'b0; dec_data = '0; dec_err = 1'b0; dec_oready = 1'b0; mem_gnt = 1'b0;
        pv = 0; pe = 0; po = 0; pd = '0; stall = 0; quiet = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: idle after reset
        cur = "R10 reset idle"; quiet = 1; repeat (4) step(); quiet = 0;

        // R1: run bit clear, all other bits set
        ctl_write(5'h1E);
        cur = "R1 disabled"; pv = 1; po = 1; pd = 8'h3C; quiet = 1;
        repeat (12) step();
        quiet = 0; pv = 0; po = 0;

        // R2 / R7: plain write from counter value 0
        stall = 1;
        ctl_write(5'h03); cur = "R2 R7 plain write"; send(10, 1); drain();

        // R3: layout bit without pointer enable
        ctl_write(5'h0B); cur = "R3 no pointers"; send(16, 2); drain();

        // R4: separated pointers
        load(1'b1, 16'h8000);
        ctl_write(5'h07); cur = "R4 separated"; send(16, 3); drain();

        // R5: mixed, pointer counter untouched, then separated resumes at it
        ctl_write(5'h0F); cur = "R5 mixed"; send(16, 4); drain();
        ctl_write(5'h07); cur = "R5 pointer counter held"; send(8, 5); drain();

        // R6: header with mixed pointers
        ctl_write(5'h1F); cur = "R6 header mixed"; send(20, 6); drain();

        // R6: header alone
        ctl_write(5'h13); cur = "R6 header only"; send(4, 7); drain();

        // R2 / R6 / R3: read direction ignores header and pointer bits
        load(1'b0, 16'h0100);
        ctl_write(5'h15); cur = "R2 R6 read direction";
        rd_cnt = 0; po = 1;
        while (rd_cnt < 10) step();
        po = 0;
        repeat (3) step();
        chk(rd_cnt == 10, "R2 read count", rd_cnt, 10);

        // R7: wrap of the stream counter
        load(1'b0, 16'hFFFE);
        ctl_write(5'h03); cur = "R7 wrap"; send(4, 8); drain();

        // R9: restart clears a partial group
        ctl_write(5'h07); cur = "R9 partial group"; send(5, 9); drain();
        ctl_write(5'h07); cur = "R9 restart group"; send(8, 10); drain();

        // R8: continuous grant run then stalls already covered above
        stall = 0;
        ctl_write(5'h1F); cur = "R8 full grant"; send(4, 11); drain();
        stall = 1;

        // R10: soft reset clears counters
        @(negedge clk);
        mem_gnt = 1'b0; soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        m_da = 0; m_pa = 0; model_start(5'h00);
        cur = "R10 soft reset idle"; quiet = 1; repeat (4) step(); quiet = 0;
        ctl_write(5'h07); cur = "R10 counters zero"; send(8, 12); drain();

        summary();
        $finish;
    end
endmodule